// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block decides which of four DMA channels owns a shared transfer engine. Each channel holds its own settings: an enable, a one-shot software start, a single/block mode choice, a selector that picks one of the peripheral request lines as its hardware trigger, and a transfer count. A channel may start when it is enabled, its terminal-count flag is clear, its count is non-zero, and either its software start or a latched peripheral request is present. The engine is modelled by a grant/acknowledge pair: the block presents a granted channel number, and the engine acknowledges each completed transfer cycle.

A winner is chosen only while the engine is idle, always the lowest-numbered eligible channel. A grant is never taken away before its acknowledge arrives. In single mode a channel performs one transfer per request and the engine goes back to idle. In block mode the channel keeps the engine until its count reaches zero. On the final transfer the block pulses a terminal-count strobe, sets the channel's terminal-count flag, and one cycle later pulses that channel's end interrupt.

Top module: `dma_req_arbiter`

## Requirements
- R1: When the engine is idle and several channels are eligible, the grant goes to the lowest channel index (0 beats 1 beats 2 beats 3).
- R2: While `grant_vld` is high and `xfer_ack` is low, `grant_vld` stays high and `grant_ch` does not change, even if a higher-priority request arrives.
- R3: In block mode (`cfg_block`=1) the granted channel holds the engine from one acknowledge to the next, with no idle cycle, until its count reaches zero; it then releases the engine.
- R4: In single mode (`cfg_block`=0) each acknowledge returns the engine to idle for one cycle, and arbitration then runs again over all pending requests.
- R5: A configuration write with `cfg_en`=1 and `cfg_start`=1 produces a grant visible two cycles after the write cycle; the start bit clears when the channel is granted, so a single-mode start yields exactly one transfer.
- R6: A pulse on `periph_req[s]` is latched as pending for every enabled channel whose source field equals `s`; pulses on unselected lines have no effect on a channel.
- R7: `tc_strobe` is high exactly in the cycle where `xfer_ack` acknowledges a channel whose remaining count is 1, and low in every other cycle.
- R8: The final transfer sets the channel's terminal-count flag; `end_irq[c]` then pulses high for one cycle, two cycles after the final acknowledge cycle. While the flag is set the channel is never granted; any configuration write to the channel clears it.
- R9: A pending request of a channel whose enable is 0 is discarded in any cycle the engine is idle, so re-enabling it later starts nothing.
- R10: A channel whose count is 0 is never granted.
- R11: After reset `grant_vld`, `tc_strobe` and `end_irq` are all low and no channel holds a start, a pending request or a set flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe for channel `cfg_ch` |
| cfg_ch | input | CH_W | Channel written by `cfg_we` |
| cfg_en | input | 1 | Enable value written |
| cfg_start | input | 1 | Software start written (taken only with `cfg_en`) |
| cfg_block | input | 1 | Mode written: 1 block, 0 single |
| cfg_src | input | SRC_W | Peripheral request line selected as trigger |
| cfg_count | input | CNT_W | Transfer count loaded |
| periph_req | input | NSRC | Peripheral request lines |
| xfer_ack | input | 1 | Engine acknowledges one completed transfer cycle |
| grant_vld | output | 1 | Engine granted to `grant_ch` |
| grant_ch | output | CH_W | Granted channel |
| tc_strobe | output | 1 | Final-transfer strobe |
| end_irq | output | NCH | Per-channel end-of-transfer pulse |

## Verification
A start from a configuration write or a peripheral pulse shows on `grant_vld` two cycles after the stimulus cycle, `tc_strobe` shows in the same cycle as its acknowledge, `end_irq` two cycles after the final acknowledge, and a single-mode channel leaves one idle cycle before the next grant. A behavioural model in the bench advances on each rising edge from the same inputs and is compared against every output half a cycle later, so every latency above is checked in every cycle. Directed checks are placed on the cycle counts listed above and on the cycles just around them.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_BUSY = 1'b1
    } arb_state_e;
endpackage

// File: rtl/dma_arb_pick.sv
// Fixed-priority selector: the lowest set index wins.
module dma_arb_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/dma_arb_chan.sv
// Per-channel settings, start/pending latches, count and end flag.
module dma_arb_chan #(
    parameter int CNT_W = 8,
    parameter int NSRC  = 4,
    parameter int SRC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             wr_en_i,
    input  logic             wr_start_i,
    input  logic             wr_blk_i,
    input  logic [SRC_W-1:0] wr_src_i,
    input  logic [CNT_W-1:0] wr_cnt_i,
    input  logic [NSRC-1:0]  periph_req_i,
    input  logic             idle_i,
    input  logic             grant_i,
    input  logic             ack_i,
    output logic             elig_o,
    output logic             last_o,
    output logic             blk_o,
    output logic             irq_o
);
    typedef struct packed {
        logic             en;
        logic             stg;
        logic             pend;
        logic             blk;
        logic [SRC_W-1:0] src;
        logic [CNT_W-1:0] cnt;
        logic             tc;
        logic             tc_prev;
        logic             irq;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     hit, drop;

    always_comb begin
        st_d       = st_q;
        hit        = periph_req_i[st_q.src] & st_q.en;
        drop       = grant_i | (idle_i & ~st_q.en);
        st_d.stg   = st_q.stg & ~drop;
        st_d.pend  = (st_q.pend & ~drop) | hit;
        st_d.tc_prev = st_q.tc;
        st_d.irq   = st_q.tc & ~st_q.tc_prev;
        if (ack_i) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
            if (st_q.cnt == CNT_W'(1)) st_d.tc = 1'b1;
        end
        if (wr_i) begin
            st_d.en  = wr_en_i;
            st_d.stg = wr_start_i & wr_en_i;
            st_d.blk = wr_blk_i;
            st_d.src = wr_src_i;
            st_d.cnt = wr_cnt_i;
            st_d.tc  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign elig_o = st_q.en & ~st_q.tc & (st_q.stg | st_q.pend) & (|st_q.cnt);
    assign last_o = (st_q.cnt == CNT_W'(1));
    assign blk_o  = st_q.blk;
    assign irq_o  = st_q.irq;
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
    import dma_arb_pkg::*;
#(
    parameter int  NCH   = 4,
    parameter int  CNT_W = 8,
    parameter int  NSRC  = 4,
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CH_W-1:0]  cfg_ch,
    input  logic             cfg_en,
    input  logic             cfg_start,
    input  logic             cfg_block,
    input  logic [SRC_W-1:0] cfg_src,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic [NSRC-1:0]  periph_req,
    input  logic             xfer_ack,
    output logic             grant_vld,
    output logic [CH_W-1:0]  grant_ch,
    output logic             tc_strobe,
    output logic [NCH-1:0]   end_irq
);
    typedef struct packed {
        arb_state_e      state;
        logic [CH_W-1:0] cur;
    } arb_st_t;

    arb_st_t         arb_d, arb_q;
    logic [NCH-1:0]  elig_v, last_v, blk_v, ack_v, grant_v;
    logic            pick_any;
    logic [CH_W-1:0] pick_idx;
    logic            idle, busy;

    assign idle = (arb_q.state == ARB_IDLE);
    assign busy = (arb_q.state == ARB_BUSY);

    dma_arb_pick #(.N(NCH), .IW(CH_W)) u_pick (
        .req (elig_v),
        .any (pick_any),
        .idx (pick_idx)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign ack_v[c]   = busy & xfer_ack & (arb_q.cur == CH_W'(c));
        assign grant_v[c] = idle & pick_any & (pick_idx == CH_W'(c));

        dma_arb_chan #(.CNT_W(CNT_W), .NSRC(NSRC), .SRC_W(SRC_W)) u_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr_i         (cfg_we & (cfg_ch == CH_W'(c))),
            .wr_en_i      (cfg_en),
            .wr_start_i   (cfg_start),
            .wr_blk_i     (cfg_block),
            .wr_src_i     (cfg_src),
            .wr_cnt_i     (cfg_count),
            .periph_req_i (periph_req),
            .idle_i       (idle),
            .grant_i      (grant_v[c]),
            .ack_i        (ack_v[c]),
            .elig_o       (elig_v[c]),
            .last_o       (last_v[c]),
            .blk_o        (blk_v[c]),
            .irq_o        (end_irq[c])
        );
    end

    always_comb begin
        arb_d = arb_q;
        if (idle && pick_any) begin
            arb_d.state = ARB_BUSY;
            arb_d.cur   = pick_idx;
        end else if (busy && xfer_ack) begin
            if (!blk_v[arb_q.cur] || last_v[arb_q.cur]) arb_d.state = ARB_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) arb_q <= '{state: ARB_IDLE, cur: '0};
        else        arb_q <= arb_d;
    end

    assign grant_vld = busy;
    assign grant_ch  = arb_q.cur;
    assign tc_strobe = busy & xfer_ack & last_v[arb_q.cur];
endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk #(
    parameter int NCH  = 4,
    parameter int CH_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            xfer_ack,
    input logic            grant_vld,
    input logic [CH_W-1:0] grant_ch,
    input logic            tc_strobe,
    input logic [NCH-1:0]  end_irq
);
    assert_hold_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && !xfer_ack) |=> (grant_vld && $stable(grant_ch)));

    assert_release_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tc_strobe |=> !grant_vld);

    assert_tc_needs_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tc_strobe |-> (grant_vld && xfer_ack));

    assert_irq_follows_tc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (end_irq != '0) |-> $past(tc_strobe, 2));

    assert_irq_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (end_irq != '0) |=> ((end_irq & $past(end_irq)) == '0));
endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(.NCH(NCH), .CH_W(CH_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer_ack  (xfer_ack),
    .grant_vld (grant_vld),
    .grant_ch  (grant_ch),
    .tc_strobe (tc_strobe),
    .end_irq   (end_irq)
);

// File: tb/tb_dma_req_arbiter.sv
`timescale 1ns/1ps
module tb_dma_req_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_ch = '0;
    logic       cfg_en = 1'b0, cfg_start = 1'b0, cfg_block = 1'b0;
    logic [1:0] cfg_src = '0;
    logic [7:0] cfg_count = '0;
    logic [3:0] periph_req = '0;
    logic       xfer_ack = 1'b0;
    logic       grant_vld, tc_strobe;
    logic [1:0] grant_ch;
    logic [3:0] end_irq;

    int  n_tests = 0, n_fail = 0, cycles = 0;
    bit  hold = 1'b0, done = 1'b0;

    always #5 clk = ~clk;

    dma_req_arbiter dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_en(cfg_en),
        .cfg_start(cfg_start), .cfg_block(cfg_block), .cfg_src(cfg_src),
        .cfg_count(cfg_count), .periph_req(periph_req), .xfer_ack(xfer_ack),
        .grant_vld(grant_vld), .grant_ch(grant_ch), .tc_strobe(tc_strobe), .end_irq(end_irq)
    );

    // engine stand-in: acknowledge every granted cycle unless held
    always @(negedge clk) begin
        #1 xfer_ack = !hold && grant_vld;
    end

    // behavioural reference model
    bit m_en[4], m_stg[4], m_pend[4], m_blk[4], m_tc[4], m_tcp[4], m_irq[4];
    int m_src[4], m_cnt[4];
    bit m_busy;
    int m_cur, win;

    function automatic bit m_elig(int c);
        return m_en[c] && !m_tc[c] && (m_stg[c] || m_pend[c]) && m_cnt[c] != 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_cur = 0;
            for (int c = 0; c < 4; c++) begin
                m_en[c] = 0; m_stg[c] = 0; m_pend[c] = 0; m_blk[c] = 0;
                m_tc[c] = 0; m_tcp[c] = 0; m_irq[c] = 0; m_src[c] = 0; m_cnt[c] = 0;
            end
        end else begin
            bit was_idle, ack_now;
            was_idle = !m_busy;
            ack_now  = m_busy && xfer_ack;
            win = -1;
            if (was_idle) begin
                for (int c = 0; c < 4; c++) if (win < 0 && m_elig(c)) win = c;
            end
            for (int c = 0; c < 4; c++) begin
                bit hit, drop;
                hit  = periph_req[m_src[c]] && m_en[c];
                drop = (win == c) || (was_idle && !m_en[c]);
                m_irq[c]  = m_tc[c] && !m_tcp[c];
                m_tcp[c]  = m_tc[c];
                m_stg[c]  = m_stg[c] && !drop;
                m_pend[c] = (m_pend[c] && !drop) || hit;
            end
            if (was_idle && win >= 0) begin
                m_busy = 1; m_cur = win;
            end else if (ack_now) begin
                if (m_cnt[m_cur] == 1) m_tc[m_cur] = 1;
                if (!m_blk[m_cur] || m_cnt[m_cur] == 1) m_busy = 0;
                m_cnt[m_cur] = (m_cnt[m_cur] - 1) & 255;
            end
            if (cfg_we) begin
                m_en[cfg_ch] = cfg_en; m_stg[cfg_ch] = cfg_start && cfg_en;
                m_blk[cfg_ch] = cfg_block; m_src[cfg_ch] = cfg_src;
                m_cnt[cfg_ch] = cfg_count; m_tc[cfg_ch] = 0;
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            int exp_irq;
            exp_irq = 0;
            for (int c = 0; c < 4; c++) if (m_irq[c]) exp_irq |= (1 << c);
            check("R1/R2/R3/R4 grant_vld vs model", grant_vld, m_busy);
            if (m_busy) check("R1/R5/R6 grant_ch vs model", grant_ch, m_cur);
            check("R7 tc_strobe vs model", tc_strobe,
                  (m_busy && xfer_ack && m_cnt[m_cur] == 1) ? 1 : 0);
            check("R8 end_irq vs model", end_irq, exp_irq);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin @(negedge clk); #3; end
    endtask

    task automatic wr(int ch, bit en, bit st, bit blk, int src, int cnt);
        cfg_we = 1; cfg_ch = 2'(ch); cfg_en = en; cfg_start = st;
        cfg_block = blk; cfg_src = 2'(src); cfg_count = 8'(cnt);
        tick();
        cfg_we = 0; cfg_start = 0;
    endtask

    task automatic pulse(logic [3:0] v);
        periph_req = v;
        tick();
        periph_req = '0;
    endtask

    initial begin
        tick(3);
        // R11: outputs quiet in reset
        check("R11 grant_vld in reset", grant_vld, 0);
        check("R11 tc_strobe in reset", tc_strobe, 0);
        check("R11 end_irq in reset", end_irq, 0);
        rst_n = 1;
        tick(2);
        check("R11 grant_vld after reset", grant_vld, 0);

        // R5: software start, single mode, one transfer only
        wr(2, 1, 1, 0, 0, 3);
        tick(); check("R5 grant_vld two cycles after write", grant_vld, 1);
        check("R5 grant_ch", grant_ch, 2);
        tick(); check("R4 idle cycle after single transfer", grant_vld, 0);
        tick(3); check("R5 start bit self-cleared", grant_vld, 0);

        // R1/R4/R6: all channels triggered by their own line at once
        for (int c = 0; c < 4; c++) wr(c, 1, 0, 0, c, 2);
        pulse(4'hF);
        tick(); check("R1 first grant is ch0", grant_ch, 0);
        check("R6 peripheral pulse granted", grant_vld, 1);
        tick(); check("R4 idle between single grants", grant_vld, 0);
        tick(); check("R1 second grant is ch1", grant_ch, 1);
        tick(2); check("R1 third grant is ch2", grant_ch, 2);
        tick(2); check("R1 fourth grant is ch3", grant_ch, 3);
        tick();

        // R2: no preemption; R7/R8 on the final transfer of ch3
        hold = 1;
        pulse(4'h8);
        tick(); check("R2 ch3 granted", grant_ch, 3);
        pulse(4'h1);
        check("R2 still ch3 with ch0 pending", grant_ch, 3);
        tick(); check("R2 held grant", grant_ch, 3);
        tick(); check("R2 held grant later", grant_ch, 3);
        hold = 0;
        tick(); check("R7 tc_strobe on final ack", tc_strobe, 1);
        tick(); check("R8 no irq yet", end_irq, 0);
        tick(); check("R8 end_irq ch3 pulse", end_irq, 4'b1000);
        tick(); check("R8 end_irq ch3 one cycle", end_irq[3], 0);

        // R8: flag blocks a start, write clears it; R3 block mode
        tick();
        pulse(4'h8);
        tick(3); check("R8 terminal flag blocks start", grant_vld, 0);
        wr(3, 1, 0, 1, 3, 2);
        tick(); check("R8 pending served after flag cleared", grant_ch, 3);
        check("R7 no tc on first block cycle", tc_strobe, 0);
        pulse(4'h2);
        check("R3 block keeps ch3", grant_vld, 1);
        check("R3 block keeps ch3 id", grant_ch, 3);
        check("R7 tc on last block cycle", tc_strobe, 1);
        tick(); check("R3 released after count end", grant_vld, 0);
        tick(); check("R4 rearbitration grants ch1", grant_ch, 1);
        tick();

        // R9: disabled channel's pending dropped at idle
        hold = 1;
        wr(0, 1, 1, 0, 0, 1);
        tick(); check("R9 ch0 granted", grant_ch, 0);
        pulse(4'h4);
        wr(2, 0, 0, 0, 2, 1);
        hold = 0;
        tick(); tick(); check("R9 disabled ch2 not granted", grant_vld, 0);
        wr(2, 1, 0, 0, 2, 1);
        tick(3); check("R9 pending dropped, re-enable starts nothing", grant_vld, 0);

        // R6: unselected line ignored, selected line starts
        pulse(4'h2);
        tick(3); check("R6 unselected line ignored", grant_vld, 0);
        pulse(4'h4);
        tick(); check("R6 selected line grants ch2", grant_ch, 2);
        check("R6 selected line grant valid", grant_vld, 1);
        tick();

        // R10: zero count never granted
        wr(1, 1, 1, 0, 1, 0);
        tick(4); check("R10 zero count not granted", grant_vld, 0);

        tick(4);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule